// File: doc/BRIEF.md
# Sinc Amplitude Threshold Detector

This block is a fast monitoring path for a one-bit delta-sigma bitstream. On every sample strobe it feeds the incoming bit into a short cascaded-integrator-comb decimator. The decimator has a programmable decimation ratio of 1 to 32 and four selectable responses. Every decimated result is turned into a signed offset from the filter's midpoint. The unsigned size of that offset is published as a 16-bit amplitude, which stays readable between updates.

Each new amplitude is compared with the previous one against a high limit and a low limit. A high event fires when the amplitude moves above the high limit. A low event fires when it drops below the low limit. A zero-crossing event fires when the sign of the offset changes. Events set sticky flags, and those flags stay set until a clear pulse. The interrupt output is the OR of the flags whose enable bits are set. The first results after enable are discarded until the filter holds a full window.

Top module: `amp_thresh_det`

## Requirements
- R1: `filt_sel` picks the response: 0 is a one-stage sinc, 1 a two-stage sinc, 2 a three-stage sinc, and 3 a fast mode (two-stage sinc followed by a two-tap sum of consecutive results). With R the decimation ratio, full scale is R, R², R³ or 2R² respectively. Once settled, `amplitude` equals |y − floor(full/2)| for the decimated result y. All-ones input gives full − floor(full/2), and all-zeros input gives floor(full/2). Alternating bits with an even R give 0.
- R2: The decimation ratio R equals `osr_m1`+1 and covers 1 to 32. One result is produced for every R accepted strobes, counted from enable.
- R3: After enable, the first 0, 1, 2 or 2 results (sinc1, sinc2, sinc3, fast) are discarded. Discarded results update neither `amplitude` nor `amp_strobe`.
- R4: If a clock edge samples the strobe that completes a block, `amplitude` and `amp_negative` take the new value at the following edge. `amp_strobe` is high for exactly that one cycle. Otherwise `amplitude` holds.
- R5: The high event (flag `flag_hi`) needs two consecutive accepted results, with the previous amplitude ≤ `hi_thresh` and the new amplitude > `hi_thresh`. Equality does not fire. Staying above the limit does not fire again.
- R6: The low event (flag `flag_lo`) needs the previous amplitude ≥ `lo_thresh` and the new amplitude < `lo_thresh`. Equality does not fire.
- R7: `amp_negative` is high when y < floor(full/2). The zero-crossing event (flag `flag_zc`) fires when this sign differs between two consecutive accepted results.
- R8: Flags are sticky until a cycle with `flag_clear` high, which clears them. An event in that same cycle leaves its flag set.
- R9: `irq` is high when any flag is set with its `irq_mask` bit set: bit 0 for high, bit 1 for low, bit 2 for zero crossing.
- R10: Deasserting `enable` clears the filter, the block count and the comparison history, but keeps `amplitude`, `amp_negative` and the flags. The first accepted result after re-enable raises no event.
- R11: Synchronous reset clears `amplitude`, `amp_negative`, `amp_strobe`, all flags and `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Run the filter; low clears filter state |
| filt_sel | input | 2 | Filter response select |
| osr_m1 | input | 5 | Decimation ratio minus one |
| smp_valid | input | 1 | Sample strobe |
| smp_bit | input | 1 | Modulator bit taken with the strobe |
| hi_thresh | input | 16 | High amplitude limit |
| lo_thresh | input | 16 | Low amplitude limit |
| irq_mask | input | 3 | Interrupt enables {zero, low, high} |
| flag_clear | input | 1 | Clears all flags |
| amplitude | output | 16 | Latest settled amplitude |
| amp_strobe | output | 1 | One-cycle pulse on amplitude update |
| amp_negative | output | 1 | Sign of the latest offset |
| flag_hi | output | 1 | Sticky high event |
| flag_lo | output | 1 | Sticky low event |
| flag_zc | output | 1 | Sticky zero-crossing event |
| irq | output | 1 | Masked OR of flags |

## Verification
Suppose the strobe that completes a block is taken at edge E. The decimated result is registered at E, and the amplitude, sign, strobe, flags and interrupt all change at E+1. A directed test samples the falling edge after E, where the amplitude must be unchanged and the strobe low. It then samples after E+1, where both must show the new value. The other tests finish each burst of strobes and wait two falling edges before sampling. The same-cycle clear test raises the clear exactly for edge E+1.

// File: rtl/amp_det_pkg.sv
package amp_det_pkg;

    localparam int OSR_W = 5;
    localparam int AMP_W = 16;
    localparam int NSTG  = 3;
    // widest full scale is (2**OSR_W)**NSTG; keep two guard bits
    localparam int ACC_W = NSTG * OSR_W + 2;

    localparam int EV_HI = 0;
    localparam int EV_LO = 1;
    localparam int EV_ZC = 2;
    localparam int EV_N  = 3;

    typedef enum logic [1:0] {
        FILT_SINC1 = 2'd0,
        FILT_SINC2 = 2'd1,
        FILT_SINC3 = 2'd2,
        FILT_FAST  = 2'd3
    } filt_e;

    typedef struct packed {
        logic             valid;
        logic [ACC_W-1:0] value;
    } cic_out_t;

    function automatic logic [31:0] full_scale(filt_e f, logic [31:0] r);
        case (f)
            FILT_SINC1: return r;
            FILT_SINC2: return r * r;
            FILT_SINC3: return r * r * r;
            default:    return 32'd2 * r * r;
        endcase
    endfunction

    function automatic logic [1:0] settle_skip(filt_e f);
        case (f)
            FILT_SINC1: return 2'd0;
            FILT_SINC2: return 2'd1;
            default:    return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/amp_sinc_decim.sv
module amp_sinc_decim
    import amp_det_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  filt_e            filt,
    input  logic [OSR_W-1:0] osr_m1,
    input  logic             smp_valid,
    input  logic             smp_bit,
    output cic_out_t         dec_out
);

    logic [ACC_W-1:0] integ_q [NSTG];
    logic [ACC_W-1:0] integ_d [NSTG];
    logic [ACC_W-1:0] dly_q   [NSTG];
    logic [ACC_W-1:0] diff    [NSTG];
    logic [ACC_W-1:0] fast_q;
    logic [ACC_W-1:0] comb_src;
    logic [ACC_W-1:0] result;
    logic [OSR_W-1:0] cnt_q;
    logic             block_end;

    // integrator chain, each stage accumulates the stage before it
    for (genvar k = 0; k < NSTG; k++) begin : g_integ
        if (k == 0) begin : g_first
            assign integ_d[k] = integ_q[k] + ACC_W'(smp_bit);
        end else begin : g_next
            assign integ_d[k] = integ_q[k] + integ_d[k-1];
        end
    end

    // comb source is the integrator whose order matches the response
    always_comb begin
        case (filt)
            FILT_SINC1: comb_src = integ_d[0];
            FILT_SINC3: comb_src = integ_d[2];
            default:    comb_src = integ_d[1];
        endcase
    end

    for (genvar k = 0; k < NSTG; k++) begin : g_comb
        if (k == 0) begin : g_first
            assign diff[k] = comb_src - dly_q[k];
        end else begin : g_next
            assign diff[k] = diff[k-1] - dly_q[k];
        end
    end

    always_comb begin
        case (filt)
            FILT_SINC1: result = diff[0];
            FILT_SINC2: result = diff[1];
            FILT_SINC3: result = diff[2];
            default:    result = diff[1] + fast_q;
        endcase
    end

    assign block_end = smp_valid && (cnt_q == osr_m1);

    always_ff @(posedge clk) begin
        if (rst || !enable) begin
            for (int k = 0; k < NSTG; k++) begin
                integ_q[k] <= '0;
                dly_q[k]   <= '0;
            end
            fast_q        <= '0;
            cnt_q         <= '0;
            dec_out.valid <= 1'b0;
            dec_out.value <= '0;
        end else begin
            dec_out.valid <= 1'b0;
            if (smp_valid) begin
                for (int k = 0; k < NSTG; k++) begin
                    integ_q[k] <= integ_d[k];
                end
                cnt_q <= block_end ? '0 : cnt_q + 1'b1;
            end
            if (block_end) begin
                dly_q[0] <= comb_src;
                for (int k = 1; k < NSTG; k++) begin
                    dly_q[k] <= diff[k-1];
                end
                fast_q        <= diff[1];
                dec_out.valid <= 1'b1;
                dec_out.value <= result;
            end
        end
    end

endmodule

// File: rtl/amp_eval.sv
module amp_eval
    import amp_det_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  filt_e            filt,
    input  logic [OSR_W-1:0] osr_m1,
    input  cic_out_t         dec_in,
    input  logic [AMP_W-1:0] hi_thresh,
    input  logic [AMP_W-1:0] lo_thresh,
    input  logic             flag_clear,
    output logic [AMP_W-1:0] amp_q,
    output logic             neg_q,
    output logic             strobe_q,
    output logic [EV_N-1:0]  flags_q
);

    logic [31:0]             fs;
    logic [ACC_W-1:0]        mid;
    logic signed [ACC_W:0]   sdiff;
    logic [ACC_W:0]          mag;
    logic [AMP_W-1:0]        amp_n;
    logic                    neg_n;
    logic [1:0]              skip_q;
    logic [1:0]              need;
    logic                    have_prev_q;
    logic                    accept;
    logic                    compare;
    logic [EV_N-1:0]         evt;

    assign fs    = full_scale(filt, 32'(osr_m1) + 32'd1);
    assign mid   = ACC_W'(fs >> 1);
    assign sdiff = $signed({1'b0, dec_in.value}) - $signed({1'b0, mid});
    assign neg_n = sdiff[ACC_W];
    assign mag   = neg_n ? $unsigned(-sdiff) : $unsigned(sdiff);
    assign amp_n = (|mag[ACC_W:AMP_W]) ? '1 : mag[AMP_W-1:0];

    assign need    = settle_skip(filt);
    assign accept  = enable && dec_in.valid && (skip_q >= need);
    assign compare = accept && have_prev_q;

    always_comb begin
        evt        = '0;
        evt[EV_HI] = compare && (amp_q <= hi_thresh) && (amp_n > hi_thresh);
        evt[EV_LO] = compare && (amp_q >= lo_thresh) && (amp_n < lo_thresh);
        evt[EV_ZC] = compare && (neg_q != neg_n);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            amp_q       <= '0;
            neg_q       <= 1'b0;
            strobe_q    <= 1'b0;
            flags_q     <= '0;
            skip_q      <= '0;
            have_prev_q <= 1'b0;
        end else begin
            flags_q <= (flags_q & ~{EV_N{flag_clear}}) | evt;
            if (!enable) begin
                skip_q      <= '0;
                have_prev_q <= 1'b0;
                strobe_q    <= 1'b0;
            end else begin
                strobe_q <= accept;
                if (dec_in.valid && (skip_q < need)) begin
                    skip_q <= skip_q + 1'b1;
                end
                if (accept) begin
                    amp_q       <= amp_n;
                    neg_q       <= neg_n;
                    have_prev_q <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/amp_thresh_det.sv
module amp_thresh_det
    import amp_det_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [1:0]       filt_sel,
    input  logic [OSR_W-1:0] osr_m1,
    input  logic             smp_valid,
    input  logic             smp_bit,
    input  logic [AMP_W-1:0] hi_thresh,
    input  logic [AMP_W-1:0] lo_thresh,
    input  logic [EV_N-1:0]  irq_mask,
    input  logic             flag_clear,
    output logic [AMP_W-1:0] amplitude,
    output logic             amp_strobe,
    output logic             amp_negative,
    output logic             flag_hi,
    output logic             flag_lo,
    output logic             flag_zc,
    output logic             irq
);

    filt_e           filt;
    cic_out_t        dec;
    logic [EV_N-1:0] flags;

    assign filt = filt_e'(filt_sel);

    amp_sinc_decim u_decim (
        .clk       (clk),
        .rst       (rst),
        .enable    (enable),
        .filt      (filt),
        .osr_m1    (osr_m1),
        .smp_valid (smp_valid),
        .smp_bit   (smp_bit),
        .dec_out   (dec)
    );

    amp_eval u_eval (
        .clk        (clk),
        .rst        (rst),
        .enable     (enable),
        .filt       (filt),
        .osr_m1     (osr_m1),
        .dec_in     (dec),
        .hi_thresh  (hi_thresh),
        .lo_thresh  (lo_thresh),
        .flag_clear (flag_clear),
        .amp_q      (amplitude),
        .neg_q      (amp_negative),
        .strobe_q   (amp_strobe),
        .flags_q    (flags)
    );

    assign flag_hi = flags[EV_HI];
    assign flag_lo = flags[EV_LO];
    assign flag_zc = flags[EV_ZC];
    assign irq     = |(flags & irq_mask);

endmodule

// File: rtl/amp_det_chk.sv
module amp_det_chk
    import amp_det_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             enable,
    input logic [AMP_W-1:0] hi_thresh,
    input logic [AMP_W-1:0] lo_thresh,
    input logic             flag_clear,
    input logic [AMP_W-1:0] amplitude,
    input logic             amp_strobe,
    input logic             flag_hi,
    input logic             flag_lo,
    input logic             flag_zc,
    input logic             irq
);

    // R8
    sticky_hi_chk: assert property (@(posedge clk) disable iff (rst)
        flag_hi && !flag_clear |=> flag_hi);

    // R8
    sticky_zc_chk: assert property (@(posedge clk) disable iff (rst)
        flag_zc && !flag_clear |=> flag_zc);

    // R5
    hi_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_hi) |-> amp_strobe && (amplitude > hi_thresh));

    // R6
    lo_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(flag_lo) |-> amp_strobe && (amplitude < lo_thresh));

    // R4
    amp_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !amp_strobe |-> $stable(amplitude));

    // R10
    strobe_en_chk: assert property (@(posedge clk) disable iff (rst)
        amp_strobe |-> $past(enable));

    // R9
    irq_src_chk: assert property (@(posedge clk) disable iff (rst)
        irq |-> (flag_hi || flag_lo || flag_zc));

endmodule

bind amp_thresh_det amp_det_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .enable     (enable),
    .hi_thresh  (hi_thresh),
    .lo_thresh  (lo_thresh),
    .flag_clear (flag_clear),
    .amplitude  (amplitude),
    .amp_strobe (amp_strobe),
    .flag_hi    (flag_hi),
    .flag_lo    (flag_lo),
    .flag_zc    (flag_zc),
    .irq        (irq)
);

// File: tb/tb_amp_thresh_det.sv
module tb_amp_thresh_det;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 12;

    typedef struct packed {
        logic [1:0]  filt;
        logic [4:0]  om1;
        logic [1:0]  pat;   // 0 zeros, 1 ones, 2 alternating
        logic [15:0] exp_amp;
        logic        exp_neg;
    } vec_t;

    localparam vec_t VECS [NV] = '{
        '{2'd0, 5'd7,  2'd1, 16'd4,     1'b0},
        '{2'd0, 5'd7,  2'd0, 16'd4,     1'b1},
        '{2'd1, 5'd15, 2'd0, 16'd128,   1'b1},
        '{2'd2, 5'd31, 2'd1, 16'd16384, 1'b0},
        '{2'd3, 5'd7,  2'd1, 16'd64,    1'b0},
        '{2'd2, 5'd3,  2'd2, 16'd0,     1'b0},
        '{2'd0, 5'd0,  2'd1, 16'd1,     1'b0},
        '{2'd1, 5'd31, 2'd1, 16'd512,   1'b0},
        '{2'd3, 5'd31, 2'd0, 16'd1024,  1'b1},
        '{2'd0, 5'd4,  2'd1, 16'd3,     1'b0},
        '{2'd0, 5'd4,  2'd0, 16'd2,     1'b1},
        '{2'd3, 5'd3,  2'd2, 16'd0,     1'b0}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        enable;
    logic [1:0]  filt_sel;
    logic [4:0]  osr_m1;
    logic        smp_valid;
    logic        smp_bit;
    logic [15:0] hi_thresh;
    logic [15:0] lo_thresh;
    logic [2:0]  irq_mask;
    logic        flag_clear;
    logic [15:0] amplitude;
    logic        amp_strobe;
    logic        amp_negative;
    logic        flag_hi;
    logic        flag_lo;
    logic        flag_zc;
    logic        irq;

    int checks = 0;
    int errors = 0;
    logic alt_q = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    amp_thresh_det dut (
        .clk          (clk),
        .rst          (rst),
        .enable       (enable),
        .filt_sel     (filt_sel),
        .osr_m1       (osr_m1),
        .smp_valid    (smp_valid),
        .smp_bit      (smp_bit),
        .hi_thresh    (hi_thresh),
        .lo_thresh    (lo_thresh),
        .irq_mask     (irq_mask),
        .flag_clear   (flag_clear),
        .amplitude    (amplitude),
        .amp_strobe   (amp_strobe),
        .amp_negative (amp_negative),
        .flag_hi      (flag_hi),
        .flag_lo      (flag_lo),
        .flag_zc      (flag_zc),
        .irq          (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // n strobes, then idle until the results have landed
    task automatic send(input int n, input int pat);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            smp_valid = 1'b1;
            smp_bit   = (pat == 1) ? 1'b1 : (pat == 2) ? alt_q : 1'b0;
            alt_q     = ~alt_q;
        end
        @(negedge clk);
        smp_valid = 1'b0;
        smp_bit   = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic restart();
        @(negedge clk);
        enable = 1'b0;
        @(negedge clk);
        enable = 1'b1;
    endtask

    task automatic pulse_clear();
        @(negedge clk);
        flag_clear = 1'b1;
        @(negedge clk);
        flag_clear = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; enable = 1'b0; filt_sel = 2'd0; osr_m1 = 5'd3;
        smp_valid = 1'b0; smp_bit = 1'b0; hi_thresh = 16'hFFFF;
        lo_thresh = 16'd0; irq_mask = 3'b000; flag_clear = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R11 reset state
        chk("R11 amplitude", amplitude, 0);
        chk("R11 flags", {flag_hi, flag_lo, flag_zc, amp_negative}, 0);
        chk("R11 irq/strobe", {irq, amp_strobe}, 0);

        // R4 latency: sinc1, R=4, ones -> full 4, mid 2, amplitude 2
        enable = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            smp_valid = 1'b1;
            smp_bit   = 1'b1;
        end
        @(negedge clk);
        smp_valid = 1'b0;
        chk("R4 strobe low at completing edge", amp_strobe, 0);
        chk("R4 amplitude unchanged at completing edge", amplitude, 0);
        @(negedge clk);
        chk("R4 strobe one edge later", amp_strobe, 1);
        chk("R4 amplitude one edge later", amplitude, 2);
        @(negedge clk);
        chk("R4 strobe is one cycle", amp_strobe, 0);

        // R3 settle discard: sinc3, R=4, ones -> 64/32 -> 32
        filt_sel = 2'd2;
        restart();
        send(8, 1);
        chk("R3 sinc3 two results discarded", amplitude, 2);
        send(4, 1);
        chk("R3 sinc3 third result accepted", amplitude, 32);

        // R1 R2 table of responses and ratios
        for (int v = 0; v < NV; v++) begin
            filt_sel = VECS[v].filt;
            osr_m1   = VECS[v].om1;
            restart();
            send(4 * (int'(VECS[v].om1) + 1), int'(VECS[v].pat));
            chk($sformatf("R1 R2 vec %0d amplitude", v), amplitude, 32'(VECS[v].exp_amp));
            chk($sformatf("R7 vec %0d sign", v), amp_negative, 32'(VECS[v].exp_neg));
        end
        chk("R1 no flag with open limits", {flag_hi, flag_lo}, 0);

        // threshold tests: sinc1, R=8, ones/zeros amp 4, alternating amp 0
        filt_sel = 2'd0; osr_m1 = 5'd7;
        hi_thresh = 16'd3; lo_thresh = 16'd1; irq_mask = 3'b001;
        restart();
        pulse_clear();
        send(24, 2);
        chk("R5 quiet below limit", {flag_hi, flag_lo, flag_zc, irq}, 0);
        send(16, 1);
        chk("R5 high event 0->4", flag_hi, 1);
        chk("R9 irq high enabled", irq, 1);
        chk("R7 no crossing 0->+4", flag_zc, 0);
        send(16, 2);
        chk("R6 low event 4->0", flag_lo, 1);
        chk("R8 high still set", flag_hi, 1);
        pulse_clear();
        chk("R8 clear", {flag_hi, flag_lo, flag_zc, irq}, 0);

        irq_mask = 3'b010;
        send(16, 1);
        chk("R5 high event again", flag_hi, 1);
        chk("R9 masked high", irq, 0);
        pulse_clear();
        send(16, 1);
        chk("R5 staying above no refire", flag_hi, 0);

        hi_thresh = 16'd4;
        send(16, 2);
        chk("R9 low enabled irq", irq, 1);
        pulse_clear();
        send(16, 1);
        chk("R5 equality no event", flag_hi, 0);
        lo_thresh = 16'd0;
        send(16, 2);
        chk("R6 equality no event", flag_lo, 0);

        // R7 zero crossing
        hi_thresh = 16'hFFFF; irq_mask = 3'b100;
        send(8, 1);
        pulse_clear();
        send(16, 0);
        chk("R7 crossing + to -", flag_zc, 1);
        chk("R7 sign negative", amp_negative, 1);
        chk("R9 zc irq", irq, 1);
        pulse_clear();
        send(16, 1);
        chk("R7 crossing - to +", flag_zc, 1);
        pulse_clear();

        // R8 event in the same cycle as clear keeps the flag
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            smp_valid = 1'b1;
            smp_bit   = 1'b0;
        end
        @(negedge clk);
        smp_valid  = 1'b0;
        flag_clear = 1'b1;
        @(negedge clk);
        flag_clear = 1'b0;
        chk("R8 set wins over clear", flag_zc, 1);

        // R10 disable keeps outputs, re-enable raises no event at first
        @(negedge clk);
        enable = 1'b0;
        repeat (3) @(negedge clk);
        chk("R10 amplitude held", amplitude, 4);
        chk("R10 sign and flag held", {amp_negative, flag_zc}, 2'b11);
        lo_thresh = 16'd1; irq_mask = 3'b000;
        pulse_clear();
        enable = 1'b1;
        send(8, 2);
        chk("R10 first result updates amplitude", amplitude, 0);
        chk("R10 first result no event", {flag_hi, flag_lo, flag_zc}, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule